// File: doc/BRIEF.md
# Framebuffer Pixel Fetch Engine

This block streams a linear RGB565 framebuffer out of external memory and turns it into a steady stream of 24-bit RGB pixels for a display pipeline. It acts as a read-only AXI4 master. It fetches the frame as incrementing bursts of 32-bit words and parks the returned words in a deep prefetch FIFO. On each clock where the timing generator flags active video, it hands one expanded pixel to the downstream encoder.

Each frame starts on a single-cycle start-of-frame strobe. The strobe reloads the read pointer from the base-address input and empties the FIFO, so every frame begins cleanly at the top-left pixel. An enable input gates the issue of new bursts. If the FIFO runs dry while pixels are being demanded, the block outputs black and raises a sticky underflow flag. The pixel clock and the memory clock are the same clock.

Top module: `fb_pixel_fetch`

## Requirements
- R1: After reset, `m_arvalid_o`, `pixel_o` and `underflow_o` are all 0, and no read request is issued before the first `sof_i` pulse.
- R2: A `sof_i` pulse reloads the read address from `base_addr_i` and discards all buffered words. Any beats still arriving from a burst in flight at that moment are dropped. The next pixels shown are those of the new base.
- R3: A burst is requested only when the FIFO has free entries for every beat of it. At most one burst is outstanding: a new request follows only after the last beat of the previous one.
- R4: Requests use 32-bit beats (`m_arsize_o` = 2), incrementing bursts (`m_arburst_o` = 1), and at most `BURST_BEATS` beats. Consecutive requests are at contiguous addresses. One frame reads exactly H_PIXELS·V_LINES/2 words, and the final burst is shortened to fit.
- R5: No burst crosses a 4096-byte address boundary; a burst that would reach past one is cut short at it.
- R6: While `fetch_en_i` is 0, no new request is issued. Raising it again resumes from the address where fetching stopped.
- R7: Each 32-bit word yields two pixels, bits 15:0 first, then bits 31:16. A halfword holds red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Each colour is widened to 8 bits by copying its top bits into the new low bits. `pixel_o` = {R[7:0], G[7:0], B[7:0]}. The pixel appears one clock after the cycle in which `active_i` was 1.
- R8: One clock after a cycle with `active_i` = 0, `pixel_o` is 0.
- R9: If the FIFO is empty in a cycle with `active_i` = 1, the next `pixel_o` is 0 and `underflow_o` becomes 1. `underflow_o` stays 1 until reset.
- R10: Once `m_arvalid_o` is raised it stays high, with the address and length unchanged, until `m_arready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and memory clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_addr_i | input | 32 | Byte address of the first pixel, sampled at start of frame (4-byte aligned) |
| fetch_en_i | input | 1 | Allows new read bursts |
| sof_i | input | 1 | Start-of-frame strobe, one cycle |
| active_i | input | 1 | Active video: one pixel wanted this cycle |
| m_arvalid_o | output | 1 | Read address valid |
| m_arready_i | input | 1 | Read address ready |
| m_araddr_o | output | 32 | Read burst start address |
| m_arlen_o | output | 8 | Beats in burst minus one |
| m_arsize_o | output | 3 | Beat size code, fixed at 2 (4 bytes) |
| m_arburst_o | output | 2 | Burst type, fixed at incrementing |
| m_rvalid_i | input | 1 | Read data valid |
| m_rready_o | output | 1 | Read data ready, always 1 |
| m_rdata_i | input | 32 | Read data beat |
| m_rlast_i | input | 1 | Last beat of burst |
| pixel_o | output | 24 | Expanded RGB888 pixel |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
The assertions assume that the memory slave returns exactly the number of beats requested and marks the final one with `m_rlast_i`. They also assume that `sof_i` never coincides with `active_i`, and that the base address is word aligned. The bench memory model answers each request with precisely arlen+1 beats, after random address and beat delays. Start-of-frame pulses are driven only during blanking, and every base address used is a multiple of 32 bytes. The line blanking gaps are randomised, but they are kept long enough that the FIFO refills in every frame except the one that deliberately starves it.

// File: rtl/fbf_pkg.sv
// Shared constants and helpers for the framebuffer pixel fetch engine.
// Assumes 32-bit memory beats carrying two packed RGB565 pixels.
package fbf_pkg;

    localparam logic [2:0] AXI_SIZE_WORD  = 3'd2;   // 4-byte beats
    localparam logic [1:0] AXI_BURST_INCR = 2'd1;   // incrementing burst
    localparam int         PAGE_BYTES     = 4096;   // burst boundary

    // Widen a 5/6/5 pixel to 8/8/8 by replicating each field's top bits.
    function automatic logic [23:0] rgb565_to_888(input logic [15:0] px);
        logic [7:0] r8;
        logic [7:0] g8;
        logic [7:0] b8;
        r8 = {px[15:11], px[15:13]};
        g8 = {px[10:5],  px[10:9]};
        b8 = {px[4:0],   px[4:2]};
        return {r8, g8, b8};
    endfunction

endpackage

// File: rtl/fbf_word_fifo.sv
// Synchronous word FIFO used as the pixel prefetch buffer.
// Assumes DEPTH is a power of two; a flush empties it in one cycle and
// takes priority over a write or read in the same cycle. Read data is
// shown ahead (valid whenever empty_o is low).
module fbf_word_fifo #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_wr;
    logic              do_rd;

    assign do_wr     = wr_en_i && !flush_i;
    assign do_rd     = rd_en_i && !flush_i && !empty_o;
    assign empty_o   = (count_o == '0);
    assign full_o    = (count_o == CNT_W'(DEPTH));
    assign rd_data_o = store[rd_ptr];

    // Storage array write port (no reset needed on data).
    always_ff @(posedge clk) begin
        if (do_wr) begin
            store[wr_ptr] <= wr_data_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    // R3: the fetch credit scheme must never push into a full buffer.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |-> !full_o);

endmodule

// File: rtl/fbf_burst_fetch.sv
// Read-burst issuer for one frame of packed pixels.
// Reloads its address from the base input at start of frame, clips each
// burst to the burst limit, the remaining frame words and the next 4 KB
// boundary, and issues only when the FIFO can hold the whole burst.
// Assumes the slave returns exactly arlen+1 beats with rlast on the last.
module fbf_burst_fetch #(
    parameter int H_PIXELS    = 800,
    parameter int V_LINES     = 600,
    parameter int BURST_BEATS = 16,
    parameter int FIFO_WORDS  = 1024,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      base_addr_i,
    input  logic             fetch_en_i,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] fifo_count_i,
    output logic             arvalid_o,
    input  logic             arready_i,
    output logic [31:0]      araddr_o,
    output logic [7:0]       arlen_o,
    input  logic             rvalid_i,
    input  logic [31:0]      rdata_i,
    input  logic             rlast_i,
    output logic             push_o,
    output logic [31:0]      push_data_o
);

    localparam int TOTAL_WORDS = H_PIXELS * V_LINES / 2;
    localparam int WL_W        = $clog2(TOTAL_WORDS + 1);
    localparam int BL_W        = 11;   // holds up to 1024 words per page

    logic            busy;        // a burst is requested or returning
    logic            stale;       // returning beats belong to a flushed frame
    logic [BL_W-1:0] beats_left;
    logic [31:0]     next_addr;
    logic [WL_W-1:0] words_left;
    logic [BL_W-1:0] page_words;
    logic [BL_W-1:0] burst_len;
    logic            room_ok;
    logic            issue;
    logic            last_beat;

    // Size of the next burst: limit, page remainder and frame remainder.
    always_comb begin
        page_words = 11'd1024 - {1'b0, next_addr[11:2]};
        burst_len  = page_words;
        if (burst_len > BL_W'(BURST_BEATS)) begin
            burst_len = BL_W'(BURST_BEATS);
        end
        if (32'(words_left) < 32'(burst_len)) begin
            burst_len = BL_W'(words_left);
        end
    end

    assign room_ok     = (32'(fifo_count_i) + 32'(burst_len)) <= 32'(FIFO_WORDS);
    assign issue       = !busy && fetch_en_i && (words_left != '0) && room_ok && !sof_i;
    assign last_beat   = rvalid_i && busy && (beats_left == BL_W'(1));
    assign push_o      = rvalid_i && busy && !stale && !sof_i;
    assign push_data_o = rdata_i;

    // Request issue, beat counting and start-of-frame reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arvalid_o  <= 1'b0;
            araddr_o   <= '0;
            arlen_o    <= '0;
            busy       <= 1'b0;
            stale      <= 1'b0;
            beats_left <= '0;
            next_addr  <= '0;
            words_left <= '0;
        end else begin
            if (arvalid_o && arready_i) begin
                arvalid_o <= 1'b0;
            end
            if (rvalid_i && busy) begin
                beats_left <= beats_left - 1'b1;
                if (last_beat) begin
                    busy  <= 1'b0;
                    stale <= 1'b0;
                end
            end
            if (sof_i) begin
                next_addr  <= base_addr_i;
                words_left <= WL_W'(TOTAL_WORDS);
                stale      <= busy && !last_beat;
            end else if (issue) begin
                arvalid_o  <= 1'b1;
                araddr_o   <= next_addr;
                arlen_o    <= 8'(burst_len - 1'b1);
                busy       <= 1'b1;
                beats_left <= burst_len;
                next_addr  <= next_addr + (32'(burst_len) << 2);
                words_left <= words_left - WL_W'(burst_len);
            end
        end
    end

    // R3: a fresh request always fits in the FIFO's free space.
    p_room_for_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arvalid_o) |-> (32'(fifo_count_i) + 32'(arlen_o) + 1) <= 32'(FIFO_WORDS));

    // R3: an accepted request is not followed by another in the next cycle.
    p_single_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid_o && arready_i) |=> !arvalid_o);

    // R4: beats returned match the requested length.
    p_rlast_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_i && busy) |-> (rlast_i == (beats_left == BL_W'(1))));

    // R4: bursts never exceed the configured beat limit.
    p_burst_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid_o |-> (32'(arlen_o) < 32'(BURST_BEATS)));

    // R5: the burst stays inside one 4 KB page.
    p_no_page_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid_o |-> ({20'd0, araddr_o[11:0]} + ((32'(arlen_o) + 1) << 2)) <= 32'd4096);

    // R10: the address phase is held stable until accepted.
    p_ar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid_o && !arready_i) |=> (arvalid_o && $stable(araddr_o) && $stable(arlen_o)));

endmodule

// File: rtl/fbf_pixel_unpack.sv
// Pixel output stage: splits each buffered word into two RGB565 pixels
// (low halfword first), widens them to RGB888 and registers the result.
// Shows black outside active video and on an empty buffer, where it also
// latches a sticky underflow flag. Assumes sof_i never meets active_i.
module fbf_pixel_unpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof_i,
    input  logic        active_i,
    input  logic [31:0] word_i,
    input  logic        empty_i,
    output logic        pop_o,
    output logic [23:0] pixel_o,
    output logic        underflow_o
);

    import fbf_pkg::*;

    logic        upper_half;   // next pixel comes from bits 31:16
    logic [15:0] half_sel;

    assign half_sel = upper_half ? word_i[31:16] : word_i[15:0];
    assign pop_o    = active_i && !empty_i && upper_half && !sof_i;

    // Pixel register, halfword selector and underflow latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pixel_o     <= '0;
            upper_half  <= 1'b0;
            underflow_o <= 1'b0;
        end else if (sof_i) begin
            pixel_o    <= '0;
            upper_half <= 1'b0;
        end else if (active_i) begin
            if (!empty_i) begin
                pixel_o    <= rgb565_to_888(half_sel);
                upper_half <= !upper_half;
            end else begin
                pixel_o     <= '0;
                underflow_o <= 1'b1;
            end
        end else begin
            pixel_o <= '0;
        end
    end

    // R8: blanking cycles produce a black pixel.
    p_idle_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (pixel_o == '0));

    // R9: starving the output gives black and raises the flag.
    p_black_on_starve_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && empty_i && !sof_i) |=> (pixel_o == '0 && underflow_o));

    // R9: the underflow flag never clears outside reset.
    p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);

endmodule

// File: rtl/fb_pixel_fetch.sv
// Framebuffer pixel fetch engine top level.
// Ties the burst issuer, the prefetch FIFO and the pixel unpacker into a
// read-only AXI4 master feeding one RGB888 pixel per active clock.
// Assumes a single clock for memory and pixels and word-aligned bases.
module fb_pixel_fetch #(
    parameter int H_PIXELS    = 800,
    parameter int V_LINES     = 600,
    parameter int BURST_BEATS = 16,
    parameter int FIFO_BYTES  = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] base_addr_i,
    input  logic        fetch_en_i,
    input  logic        sof_i,
    input  logic        active_i,
    output logic        m_arvalid_o,
    input  logic        m_arready_i,
    output logic [31:0] m_araddr_o,
    output logic [7:0]  m_arlen_o,
    output logic [2:0]  m_arsize_o,
    output logic [1:0]  m_arburst_o,
    input  logic        m_rvalid_i,
    output logic        m_rready_o,
    input  logic [31:0] m_rdata_i,
    input  logic        m_rlast_i,
    output logic [23:0] pixel_o,
    output logic        underflow_o
);

    import fbf_pkg::*;

    localparam int FIFO_WORDS = FIFO_BYTES / 4;
    localparam int CNT_W      = $clog2(FIFO_WORDS + 1);

    logic             push;
    logic [31:0]      push_data;
    logic             pop;
    logic [31:0]      head_word;
    logic             fifo_empty;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_count;

    assign m_arsize_o  = AXI_SIZE_WORD;
    assign m_arburst_o = AXI_BURST_INCR;
    assign m_rready_o  = 1'b1;   // space is reserved before each request

    fbf_burst_fetch #(
        .H_PIXELS    (H_PIXELS),
        .V_LINES     (V_LINES),
        .BURST_BEATS (BURST_BEATS),
        .FIFO_WORDS  (FIFO_WORDS),
        .CNT_W       (CNT_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_addr_i  (base_addr_i),
        .fetch_en_i   (fetch_en_i),
        .sof_i        (sof_i),
        .fifo_count_i (fifo_count),
        .arvalid_o    (m_arvalid_o),
        .arready_i    (m_arready_i),
        .araddr_o     (m_araddr_o),
        .arlen_o      (m_arlen_o),
        .rvalid_i     (m_rvalid_i),
        .rdata_i      (m_rdata_i),
        .rlast_i      (m_rlast_i),
        .push_o       (push),
        .push_data_o  (push_data)
    );

    fbf_word_fifo #(
        .DEPTH  (FIFO_WORDS),
        .DATA_W (32)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (sof_i),
        .wr_en_i   (push),
        .wr_data_i (push_data),
        .rd_en_i   (pop),
        .rd_data_o (head_word),
        .empty_o   (fifo_empty),
        .full_o    (fifo_full),
        .count_o   (fifo_count)
    );

    fbf_pixel_unpack u_unpack (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .active_i    (active_i),
        .word_i      (head_word),
        .empty_i     (fifo_empty),
        .pop_o       (pop),
        .pixel_o     (pixel_o),
        .underflow_o (underflow_o)
    );

    // R3: the buffer is never full while data is being written into it.
    p_full_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push);

endmodule

// File: tb/fb_pixel_fetch_bench.sv
module fb_pixel_fetch_bench;

    localparam int H  = 16;
    localparam int V  = 8;
    localparam int BB = 16;
    localparam int FB = 128;   // 32-word FIFO

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = 32'h0300_0000;
    logic        fetch_en = 1'b1;
    logic        sof = 1'b0;
    logic        active = 1'b0;
    logic        arvalid;
    logic        arready;
    logic [31:0] araddr;
    logic [7:0]  arlen;
    logic [2:0]  arsize;
    logic [1:0]  arburst;
    logic        rvalid;
    logic        rready;
    logic [31:0] rdata;
    logic        rlast;
    logic [23:0] pixel;
    logic        underflow;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    fb_pixel_fetch #(.H_PIXELS(H), .V_LINES(V), .BURST_BEATS(BB), .FIFO_BYTES(FB)) u_fb_pixel_fetch (
        .clk(clk), .rst_n(rst_n), .base_addr_i(base_addr), .fetch_en_i(fetch_en),
        .sof_i(sof), .active_i(active),
        .m_arvalid_o(arvalid), .m_arready_i(arready), .m_araddr_o(araddr),
        .m_arlen_o(arlen), .m_arsize_o(arsize), .m_arburst_o(arburst),
        .m_rvalid_i(rvalid), .m_rready_o(rready), .m_rdata_i(rdata), .m_rlast_i(rlast),
        .pixel_o(pixel), .underflow_o(underflow)
    );

    // Memory content as a function of address, with two directed patterns.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[5:2] == 4'd1) return 32'hFFFF_0000;
        if (a[5:2] == 4'd2) return 32'h07E0_F81F;
        return (a * 32'h9E37_79B1) ^ 32'h5BD1_E995;
    endfunction

    function automatic logic [23:0] exp_pixel(input logic [31:0] b, input int p);
        logic [31:0] w;
        logic [15:0] h;
        w = mem_word(b + 32'((p / 2) * 4));
        h = (p % 2 == 1) ? w[31:16] : w[15:0];
        return {h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
    endfunction

    // Memory slave model: random address and beat delays.
    logic [31:0] m_addr;
    int          m_beats = 0;
    int          ar_cnt = 0;
    int          r_hs = 0;
    logic [31:0] ar_addr_log [64];
    logic [7:0]  ar_len_log  [64];

    always @(posedge clk) begin
        if (!rst_n) begin
            arready <= 1'b0;
            rvalid  <= 1'b0;
            rdata   <= '0;
            rlast   <= 1'b0;
            m_beats = 0;
        end else begin
            if (rvalid && rready) begin
                m_addr  = m_addr + 32'd4;
                m_beats = m_beats - 1;
                r_hs    = r_hs + 1;
            end
            if (arvalid && arready) begin
                if (ar_cnt < 64) begin
                    ar_addr_log[ar_cnt] = araddr;
                    ar_len_log[ar_cnt]  = arlen;
                end
                ar_cnt  = ar_cnt + 1;
                m_addr  = araddr;
                m_beats = int'(arlen) + 1;
            end
            arready <= (m_beats == 0) && ($urandom % 4 != 0);
            if (m_beats > 0 && ($urandom % 4 != 0)) begin
                rvalid <= 1'b1;
                rdata  <= mem_word(m_addr);
                rlast  <= (m_beats == 1);
            end else begin
                rvalid <= 1'b0;
                rlast  <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_sof(input logic [31:0] b);
        @(negedge clk);
        base_addr = b;
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    // One active line: drive active each cycle, check the pixel a cycle later.
    task automatic run_line(input logic [31:0] b, input int first_p, input bit starve);
        for (int i = 0; i < H; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (starve) chk("R9 black pixel", 32'(pixel), 32'd0);
                else        chk("R7 pixel", 32'(pixel), 32'(exp_pixel(b, first_p + i - 1)));
            end
            active = 1'b1;
        end
        @(negedge clk);
        if (starve) chk("R9 black pixel", 32'(pixel), 32'd0);
        else        chk("R7 pixel", 32'(pixel), 32'(exp_pixel(b, first_p + H - 1)));
        active = 1'b0;
        @(negedge clk);
        chk("R8 blank black", 32'(pixel), 32'd0);
        repeat (30 + ($urandom % 30)) @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] b);
        for (int ln = 0; ln < V; ln++) run_line(b, ln * H, 1'b0);
    endtask

    initial begin
        int start;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 arvalid reset", 32'(arvalid), 32'd0);
        chk("R1 pixel reset", 32'(pixel), 32'd0);
        chk("R1 underflow reset", 32'(underflow), 32'd0);
        chk("R4 arsize", 32'(arsize), 32'd2);
        chk("R4 arburst", 32'(arburst), 32'd1);
        repeat (30) @(negedge clk);
        chk("R1 no fetch before sof", 32'(ar_cnt), 32'd0);

        // Frame 1: credit limit, then a full frame of pixels.
        start = ar_cnt;
        pulse_sof(32'h0300_0000);
        repeat (200) @(negedge clk);
        chk("R3 only bursts that fit", 32'(ar_cnt - start), 32'd2);
        run_frame(32'h0300_0000);
        chk("R4 burst count", 32'(ar_cnt - start), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R4 burst addr", ar_addr_log[start + k], 32'h0300_0000 + 32'(k * 64));
            chk("R4 burst len", 32'(ar_len_log[start + k]), 32'd15);
        end

        // Frame 2: base near a 4 KB boundary.
        start = ar_cnt;
        pulse_sof(32'h0300_0FE0);
        repeat (200) @(negedge clk);
        run_frame(32'h0300_0FE0);
        chk("R5 burst count", 32'(ar_cnt - start), 32'd5);
        chk("R5 clipped addr", ar_addr_log[start], 32'h0300_0FE0);
        chk("R5 clipped len", 32'(ar_len_log[start]), 32'd7);
        chk("R5 next page addr", ar_addr_log[start + 1], 32'h0300_1000);
        chk("R5 next page len", 32'(ar_len_log[start + 1]), 32'd15);
        chk("R4 short last addr", ar_addr_log[start + 4], 32'h0300_10C0);
        chk("R4 short last len", 32'(ar_len_log[start + 4]), 32'd7);

        // Frame 3: enable gating and resume.
        start = ar_cnt;
        @(negedge clk);
        fetch_en = 1'b0;
        pulse_sof(32'h0300_6000);
        repeat (100) @(negedge clk);
        chk("R6 no fetch while disabled", 32'(ar_cnt - start), 32'd0);
        fetch_en = 1'b1;
        repeat (200) @(negedge clk);
        chk("R6 resume count", 32'(ar_cnt - start), 32'd2);
        chk("R6 resume addr", ar_addr_log[start], 32'h0300_6000);
        run_frame(32'h0300_6000);

        // Frame 4: restart mid-burst; stale beats must be dropped.
        pulse_sof(32'h0300_2000);
        start = r_hs;
        while (r_hs < start + 3) @(negedge clk);
        start = ar_cnt;
        pulse_sof(32'h0300_4000);
        repeat (250) @(negedge clk);
        chk("R2 restart addr", ar_addr_log[start], 32'h0300_4000);
        run_frame(32'h0300_4000);

        // Frame 5: starve the output.
        chk("R9 no underflow yet", 32'(underflow), 32'd0);
        fetch_en = 1'b0;
        pulse_sof(32'h0300_8000);
        repeat (20) @(negedge clk);
        run_line(32'h0300_8000, 0, 1'b1);
        chk("R9 underflow set", 32'(underflow), 32'd1);
        repeat (20) @(negedge clk);
        chk("R9 underflow sticky", 32'(underflow), 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule